// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This controller decides when the two supply rails of a system are switched on and off. It drives a switching-regulator enable and a linear-regulator enable. It watches an active-low pushbutton, two host enable-request lines, an external-supply-valid flag, a battery-present flag and an output undervoltage flag.

The controller is always in one of four states: off, rising (sequencing up), on, or a power-down hold. All timing counts pulses on a millisecond tick input, and every duration is a parameter.

From the off state, a debounced press starts a power-up, but only when some source of energy exists. The switching rail comes up first and the linear rail follows one stagger period later. While the rails are on, a debounced press produces a fixed-width active-low status pulse for the host and leaves the rails alone. The host shuts the system down by releasing both request lines.

Each power-down passes through a hold window in which every input is ignored. After a host shutdown, the button must then be seen released and pressed again before a new power-up. An undervoltage event cuts both rails at once and holds them off for a longer minimum time. If external power is valid when that time ends, the controller restarts by itself.

Top module: `pb_power_seq`

## Requirements
- R1: After reset both regulator enables are low and the status output is high.
- R2: In the off state, a button held low for DEB_MS ticks (counted only after the button was seen high) raises the switching enable on that tick, but only if bat_ok or ext_ok is high. Otherwise both enables stay low.
- R3: In the rising state the switching enable is high and the linear enable is low. On the STAGGER_MS-th tick after entry the linear enable rises as well. The linear enable is never high while the switching enable is low.
- R4: With both rails on, a button held low for DEB_MS ticks drives pb_stat_n low for PULSE_MS ticks and leaves both enables high. A press yields one pulse however long it is held.
- R5: With both rails on, the cycle in which the last of req_sw and req_lin falls is followed by both enables low.
- R6: A host-initiated power-down holds the rails off for WAIT_MS ticks. During that time button activity, request lines and ext_ok have no effect, and pb_stat_n stays high.
- R7: A button held low through the power-down hold does not power up afterwards. A release followed by a new DEB_MS-tick press is needed.
- R8: uv_flag high with both rails on drops both enables in the next cycle. The rails stay off for MINOFF_MS ticks. If ext_ok is high at the end the controller re-enters the rising state; otherwise it stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| btn_n | input | 1 | Pushbutton, low when pressed |
| req_sw | input | 1 | Host request for the switching rail |
| req_lin | input | 1 | Host request for the linear rail |
| ext_ok | input | 1 | External supply valid |
| bat_ok | input | 1 | Battery present |
| uv_flag | input | 1 | Output undervoltage lockout |
| en_sw | output | 1 | Switching regulator enable |
| en_lin | output | 1 | Linear regulator enable |
| pb_stat_n | output | 1 | Debounced button status pulse, active low |

## Verification
Some properties can be checked on every cycle. The assertions cover the one-hot state, the ordering of the linear enable behind the switching enable, and the next-cycle rail drop after the last request falls or undervoltage appears. They also check that the power-down hold never ends without a tick and that no rail rises while no energy source is present. Other behaviour can only be shown by running stimulus sequences through the bench. This includes the exact tick counts of debounce, stagger, hold and minimum-off windows, and the ignoring of a release during the hold. It also includes the demand for a fresh press afterwards and the choice between automatic restart and staying off.

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
  parameter int DEB_MS     = 50,
  parameter int PULSE_MS   = 50,
  parameter int WAIT_MS    = 1000,
  parameter int MINOFF_MS  = 5000,
  parameter int STAGGER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic btn_n,
  input  logic req_sw,
  input  logic req_lin,
  input  logic ext_ok,
  input  logic bat_ok,
  input  logic uv_flag,
  output logic en_sw,
  output logic en_lin,
  output logic pb_stat_n
);
  localparam int M1   = (WAIT_MS > MINOFF_MS) ? WAIT_MS : MINOFF_MS;
  localparam int M2   = (DEB_MS > PULSE_MS) ? DEB_MS : PULSE_MS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > STAGGER_MS) ? M3 : STAGGER_MS;
  localparam int CW   = $clog2(MAXT + 1);

  localparam logic [3:0] S_OFF = 4'b0001;
  localparam logic [3:0] S_PUP = 4'b0010;
  localparam logic [3:0] S_ON  = 4'b0100;
  localparam logic [3:0] S_PDN = 4'b1000;

  logic [3:0]    st, nx;
  logic [CW-1:0] cnt, deb, pls;
  logic          armed, uv_pd, req_q;

  wire st_pup  = (st == S_PUP);
  wire st_on   = (st == S_ON);
  wire st_pdn  = (st == S_PDN);
  wire st_off  = (st == S_OFF);
  wire req_any = req_sw | req_lin;

  wire press   = tick_ms & armed & ~btn_n & ~st_pdn & (deb == CW'(DEB_MS - 1));
  wire pu_done = tick_ms & (cnt == CW'(STAGGER_MS - 1));
  wire pd_done = tick_ms & (cnt == (uv_pd ? CW'(MINOFF_MS - 1) : CW'(WAIT_MS - 1)));

  always_comb begin
    case (st)
      S_OFF:   nx = (press && (bat_ok || ext_ok)) ? S_PUP : S_OFF;
      S_PUP:   nx = pu_done ? S_ON : S_PUP;
      S_ON:    nx = (uv_flag || (req_q && !req_any)) ? S_PDN : S_ON;
      S_PDN:   nx = pd_done ? ((uv_pd && ext_ok) ? S_PUP : S_OFF) : S_PDN;
      default: nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      deb   <= '0;
      pls   <= '0;
      armed <= 1'b0;
      uv_pd <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st    <= nx;
      req_q <= req_any;

      if (nx != st)
        cnt <= '0;
      else if (tick_ms && (st_pup || st_pdn))
        cnt <= cnt + 1'b1;

      if (st_on && uv_flag)
        uv_pd <= 1'b1;
      else if (st_pdn && pd_done)
        uv_pd <= 1'b0;

      if (st_pdn || nx == S_PDN)
        armed <= 1'b0;
      else if (btn_n)
        armed <= 1'b1;
      else if (press)
        armed <= 1'b0;

      if (st_pdn || btn_n || !armed || press)
        deb <= '0;
      else if (tick_ms)
        deb <= deb + 1'b1;

      if (!st_on || nx != S_ON)
        pls <= '0;
      else if (press)
        pls <= CW'(PULSE_MS);
      else if (tick_ms && pls != '0)
        pls <= pls - 1'b1;
    end
  end

  assign en_sw     = st_pup | st_on;
  assign en_lin    = st_on;
  assign pb_stat_n = (pls == '0);

  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);

  // R3
  stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_lin |-> en_sw);

  // R5
  last_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && req_q && !req_any) |=> (!en_sw && !en_lin));

  // R8
  uv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && uv_flag) |=> (!en_sw && !en_lin));

  // R6
  pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pdn && !tick_ms) |=> st_pdn);

  // R2
  nopower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_off && !bat_ok && !ext_ok) |=> !en_sw);

  // R4
  pulse_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_stat_n |-> (en_sw && en_lin));
endmodule

// File: tb/pb_power_seq_test.sv
`timescale 1ns/1ps
module pb_power_seq_test;
  localparam int DEB = 3, PUL = 2, WT = 4, MOFF = 6, STG = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, btn_n = 1'b1;
  logic req_sw = 1'b0, req_lin = 1'b0, ext_ok = 1'b0, bat_ok = 1'b0, uv_flag = 1'b0;
  logic en_sw, en_lin, pb_stat_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pb_power_seq #(.DEB_MS(DEB), .PULSE_MS(PUL), .WAIT_MS(WT),
                 .MINOFF_MS(MOFF), .STAGGER_MS(STG)) uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
    .req_sw(req_sw), .req_lin(req_lin), .ext_ok(ext_ok), .bat_ok(bat_ok),
    .uv_flag(uv_flag), .en_sw(en_sw), .en_lin(en_lin), .pb_stat_n(pb_stat_n));

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; cyc(); tick_ms = 1'b0;
    end
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {en_sw,en_lin,pb_stat_n} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {en_sw, en_lin, pb_stat_n};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst_n = 1'b1; cyc();
    chk("R1", outs(), 3'b001);

    // R2: no energy source, press is lost
    btn_n = 1'b0; tk(DEB + 2);
    chk("R2", outs(), 3'b001);
    btn_n = 1'b1; cyc(); bat_ok = 1'b1;
    btn_n = 1'b0; tk(DEB - 1);
    chk("R2", outs(), 3'b001);
    tk(1);
    chk("R2", outs(), 3'b101);
    btn_n = 1'b1; req_sw = 1'b1; req_lin = 1'b1;

    // R3: stagger
    tk(STG - 1);
    chk("R3", outs(), 3'b101);
    tk(1);
    chk("R3", outs(), 3'b111);

    // R4: status pulse
    cyc(); btn_n = 1'b0; tk(DEB - 1);
    chk("R4", outs(), 3'b111);
    tk(1);
    chk("R4", outs(), 3'b110);
    tk(PUL - 1);
    chk("R4", outs(), 3'b110);
    tk(1);
    chk("R4", outs(), 3'b111);
    tk(DEB + 2);
    chk("R4", outs(), 3'b111);
    btn_n = 1'b1; cyc();

    // R5: last request falls
    req_sw = 1'b0; cyc();
    chk("R5", outs(), 3'b111);
    req_lin = 1'b0; cyc();
    chk("R5", outs(), 3'b001);

    // R6: ignored inputs during hold
    btn_n = 1'b0; req_sw = 1'b1; req_lin = 1'b1; ext_ok = 1'b1;
    tk(2);
    btn_n = 1'b1; cyc(); btn_n = 1'b0; cyc();
    tk(WT - 3);
    chk("R6", outs(), 3'b001);
    req_sw = 1'b0; req_lin = 1'b0; ext_ok = 1'b0;
    tk(1);

    // R7: held button must be released first
    tk(DEB + 2);
    chk("R7", outs(), 3'b001);
    btn_n = 1'b1; cyc(); btn_n = 1'b0;
    tk(DEB - 1);
    chk("R7", outs(), 3'b001);
    tk(1);
    chk("R7", outs(), 3'b101);
    btn_n = 1'b1; req_sw = 1'b1; req_lin = 1'b1;
    tk(STG - 1);
    chk("R3", outs(), 3'b101);
    tk(1);
    chk("R3", outs(), 3'b111);

    // R8: undervoltage with restart
    uv_flag = 1'b1; cyc(); uv_flag = 1'b0;
    chk("R8", outs(), 3'b001);
    ext_ok = 1'b1;
    tk(MOFF - 1);
    chk("R8", outs(), 3'b001);
    tk(1);
    chk("R8", outs(), 3'b101);
    tk(STG);
    chk("R8", outs(), 3'b111);

    // R8: undervoltage without external power stays off
    ext_ok = 1'b0;
    uv_flag = 1'b1; cyc(); uv_flag = 1'b0;
    chk("R8", outs(), 3'b001);
    tk(MOFF + 3);
    chk("R8", outs(), 3'b001);

    // R2: external supply alone enables power-up
    bat_ok = 1'b0; ext_ok = 1'b1;
    btn_n = 1'b1; cyc(); btn_n = 1'b0;
    tk(DEB);
    chk("R2", outs(), 3'b101);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule